// File: doc/BRIEF.md
# Convert-Start Sequencer with Settling Pulse

This block decides when a sampling front end stops tracking and a conversion begins. A rising edge on the convert-start input asks for a conversion. An internal settling timer, loaded with a programmable cycle count each time the input channel selection changes, gives an external filter or buffer time to settle. A request that arrives after the timer has run out starts the conversion at once. A request that arrives while the timer is still running is held back and starts on the first clock edge after the timer expires. It is deferred, not dropped.

When a conversion starts, the block raises a hold control and issues a one-cycle start strobe to the converter core. It keeps hold and a busy flag asserted until the core returns a conversion-done indication. Everything runs on the single system clock. The timer stands in for an analog one-shot pulse.

Top module: `conv_start_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `hold_o`, `start_o` and `busy_o` are 0 and the settling timer is idle.
- R2: Only a 0-to-1 change of `conv_start_i` between two sampled clock edges requests a conversion. A level held high does not request a conversion, even a level held high through reset and after its release.
- R3: At any edge where `chan_sel_i` differs from its value at the previous edge, the settling timer loads `settle_len_i`. The pulse is then active for `settle_len_i` cycles. A length of 0 gives no pulse.
- R4: A rising edge sampled while the timer is not active starts a conversion at that edge. In the following cycle `start_o`, `hold_o` and `busy_o` are 1.
- R5: A rising edge sampled while the timer is active is deferred. `busy_o` is 1 and `hold_o` is 0 while the request waits, and the conversion starts at the first edge at which the timer is no longer active. For a channel change sampled at edge N and a rising edge sampled at edge N+g with 1 <= g <= L, the start follows edge N+L+1.
- R6: A channel change sampled while a request is waiting reloads the timer and pushes the start back to the end of the new pulse.
- R7: `start_o` is high for exactly one cycle for each accepted request.
- R8: Rising edges of `conv_start_i` sampled while `busy_o` is 1 are ignored. This holds both while a request waits and while a conversion runs. No second start follows.
- R9: `hold_o` and `busy_o` stay 1 until `conv_done_i` is sampled high during a conversion. Both are 0 in the cycle after that edge.
- R10: `conv_done_i` sampled while no conversion is running has no effect. The outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| conv_start_i | input | 1 | Convert-start request, edge sensitive |
| chan_sel_i | input | CH_W | Selected input channel; a change restarts the settling pulse |
| settle_len_i | input | CNT_W | Settling pulse length in clock cycles |
| conv_done_i | input | 1 | Conversion-finished indication from the converter core |
| hold_o | output | 1 | 1 = hold, 0 = track |
| start_o | output | 1 | One-cycle start-conversion strobe |
| busy_o | output | 1 | A request is waiting or a conversion is running |

## Verification
The main function is driven from a vector table that varies the pulse length and the gap between a channel change and the convert edge. The gaps include zero, gaps inside the pulse, a gap equal to the pulse length, gaps past its end, and a zero-length pulse. Together these separate an immediate start from a deferred one and pin down the boundary cycle where one turns into the other. Directed runs then cover:
- a level held high through reset;
- a done pulse while idle;
- a reload of the pulse while a request waits, with a second rising edge during the wait;
- a rising edge during a running conversion, which must neither restart the conversion nor queue a later one.

// File: rtl/conv_start_pkg.sv
package conv_start_pkg;

    // default widths
    localparam int DEF_CNT_W = 8;
    localparam int DEF_CH_W  = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_e;

    // next-state decision bundle
    typedef struct packed {
        seq_state_e state;
        logic       start;
    } seq_step_t;

    function automatic logic state_busy(input seq_state_e s);
        return s != SEQ_IDLE;
    endfunction

    function automatic logic state_hold(input seq_state_e s);
        return s == SEQ_CONV;
    endfunction

endpackage

// File: rtl/cs_edge_detect.sv
module cs_edge_detect (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    // reset high so a level already high after reset is not an edge
    always_ff @(posedge clk_i) begin
        if (rst_i) level_q <= 1'b1;
        else       level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;

    assert_rise_from_low_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> level_q);

endmodule

// File: rtl/cs_settle_timer.sv
module cs_settle_timer #(
    parameter int CNT_W = 8,
    parameter int CH_W  = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             active_o
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CH_W-1:0]  chan_q;
    logic [CNT_W-1:0] cnt_q;
    logic             chg;

    assign chg = chan_i != chan_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chan_q <= '0;
            cnt_q  <= CNT_ZERO;
        end else begin
            chan_q <= chan_i;
            if (chg)                 cnt_q <= len_i;
            else if (cnt_q != CNT_ZERO) cnt_q <= cnt_q - CNT_ONE;
        end
    end

    assign active_o = cnt_q != CNT_ZERO;

    assert_count_down_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!chg && cnt_q != CNT_ZERO) |=> cnt_q == $past(cnt_q) - CNT_ONE);

    assert_idle_stays_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!chg && !active_o) |=> !active_o);

endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
    import conv_start_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic rise_i,
    input  logic settle_active_i,
    input  logic done_i,
    output logic hold_o,
    output logic start_o,
    output logic busy_o
);
    seq_state_e state_q;
    logic       start_q;
    seq_step_t  nxt;

    always_comb begin
        nxt.state = state_q;
        nxt.start = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (rise_i) begin
                    if (settle_active_i) begin
                        nxt.state = SEQ_WAIT;
                    end else begin
                        nxt.state = SEQ_CONV;
                        nxt.start = 1'b1;
                    end
                end
            end
            SEQ_WAIT: begin
                if (!settle_active_i) begin
                    nxt.state = SEQ_CONV;
                    nxt.start = 1'b1;
                end
            end
            SEQ_CONV: begin
                if (done_i) nxt.state = SEQ_IDLE;
            end
            default: nxt.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEQ_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= nxt.state;
            start_q <= nxt.start;
        end
    end

    assign hold_o  = state_hold(state_q);
    assign busy_o  = state_busy(state_q);
    assign start_o = start_q;

    assert_single_strobe_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        start_o |=> !start_o);

    assert_hold_with_start_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hold_o) |-> start_o);

    assert_no_start_settling_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        start_o |-> !$past(settle_active_i));

    assert_release_on_done_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(hold_o) |-> $past(done_i));

    assert_busy_ignores_edge_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (hold_o && !done_i) |=> (hold_o && !start_o));

    assert_idle_done_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && !rise_i) |=> !busy_o);

endmodule

// File: rtl/conv_start_seq.sv
module conv_start_seq
    import conv_start_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int CH_W  = DEF_CH_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             conv_start_i,
    input  logic [CH_W-1:0]  chan_sel_i,
    input  logic [CNT_W-1:0] settle_len_i,
    input  logic             conv_done_i,
    output logic             hold_o,
    output logic             start_o,
    output logic             busy_o
);
    logic rise;
    logic settle_active;

    cs_edge_detect u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (conv_start_i),
        .rise_o  (rise)
    );

    cs_settle_timer #(
        .CNT_W (CNT_W),
        .CH_W  (CH_W)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .chan_i   (chan_sel_i),
        .len_i    (settle_len_i),
        .active_o (settle_active)
    );

    cs_seq_fsm u_fsm (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .rise_i          (rise),
        .settle_active_i (settle_active),
        .done_i          (conv_done_i),
        .hold_o          (hold_o),
        .start_o         (start_o),
        .busy_o          (busy_o)
    );

    assert_reset_idle_R1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!hold_o && !start_o && !busy_o));

endmodule

// File: tb/conv_start_seq_tb.sv
module conv_start_seq_tb_top;

    localparam int CNT_W = 8;
    localparam int CH_W  = 3;
    localparam int NVEC  = 8;
    localparam int WATCHDOG_CYC = 20000;

    // pulse length, gap (edges from channel change to convert edge)
    localparam int VEC_LEN [NVEC] = '{5, 5, 5, 5, 0, 3, 8, 12};
    localparam int VEC_GAP [NVEC] = '{0, 2, 5, 6, 1, 1, 9, 4};

    logic             clk = 1'b0;
    logic             rst;
    logic             conv_start;
    logic [CH_W-1:0]  chan_sel;
    logic [CNT_W-1:0] settle_len;
    logic             conv_done;
    logic             hold, start, busy;

    int errors = 0;
    int checks = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    conv_start_seq #(.CNT_W(CNT_W), .CH_W(CH_W)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .conv_start_i (conv_start),
        .chan_sel_i   (chan_sel),
        .settle_len_i (settle_len),
        .conv_done_i  (conv_done),
        .hold_o       (hold),
        .start_o      (start),
        .busy_o       (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    endtask

    task automatic finish_conv(input string req);
        @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk(hold == 1'b0, {req, " hold after done"}, int'(hold), 0);
        chk(busy == 1'b0, {req, " busy after done"}, int'(busy), 0);
    endtask

    initial begin
        #(WATCHDOG_CYC * 8);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int d;
        int exp_d;
        int nstart;
        rst        = 1'b1;
        conv_start = 1'b1;   // held high through reset (R2)
        chan_sel   = '0;
        settle_len = '0;
        conv_done  = 1'b0;
        repeat (3) @(negedge clk);
        // R1: idle outputs in reset
        chk(hold == 0 && start == 0 && busy == 0, "R1 reset outputs",
            int'({hold, start, busy}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(hold == 0 && start == 0 && busy == 0, "R1 first cycle after reset",
            int'({hold, start, busy}), 0);
        repeat (3) @(negedge clk);
        chk(busy == 0, "R2 level high from reset no request", int'(busy), 0);
        conv_start = 1'b0;
        @(negedge clk);

        // R10: done while idle ignored
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk(hold == 0 && busy == 0 && start == 0, "R10 done while idle",
            int'({hold, start, busy}), 0);
        @(negedge clk);

        // vector table: R3 R4 R5 R7 R9
        for (int v = 0; v < NVEC; v++) begin
            settle_len = CNT_W'(VEC_LEN[v]);
            exp_d = (VEC_GAP[v] >= 1 && VEC_GAP[v] <= VEC_LEN[v])
                    ? VEC_LEN[v] + 1 - VEC_GAP[v] : 0;
            chan_sel = chan_sel + 1'b1;          // sampled at edge N
            for (int g = 0; g < VEC_GAP[v]; g++) @(negedge clk);
            conv_start = 1'b1;                   // sampled at edge N+gap
            d = -1;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (start) begin
                    d = k;
                    break;
                end
                if (k == 0) begin
                    chk(busy == 1 && hold == 0, "R5 waiting busy no hold",
                        int'({busy, hold}), 2);
                end
            end
            chk(d == exp_d, exp_d == 0 ? "R4 immediate start cycle" : "R5 deferred start cycle",
                d, exp_d);
            chk(hold == 1 && busy == 1, "R4 hold and busy with start",
                int'({hold, busy}), 3);
            @(negedge clk);
            conv_start = 1'b0;
            chk(start == 0, "R7 strobe one cycle", int'(start), 0);
            finish_conv("R9");
            repeat (VEC_LEN[v] + 2) @(negedge clk);
        end

        // R6 and R8: reload during wait, extra edge during wait
        settle_len = CNT_W'(6);
        chan_sel   = chan_sel + 1'b1;            // edge N
        @(negedge clk);
        @(negedge clk);
        conv_start = 1'b1;                       // edge N+2, deferred
        d = -1;
        nstart = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (start) begin
                nstart++;
                if (d < 0) d = k;
            end
            if (k == 0) begin
                chan_sel   = chan_sel + 1'b1;    // reload at edge N+3
                conv_start = 1'b0;
            end
            if (k == 1) conv_start = 1'b1;       // rise while waiting (R8)
            if (k == 2) conv_start = 1'b0;
        end
        chk(d == 8, "R6 reload extends deferral", d, 8);
        chk(nstart == 1, "R8 one start despite edge while waiting", nstart, 1);

        // R8: edge during conversion ignored, nothing queued
        chk(hold == 1, "R9 hold kept until done", int'(hold), 1);
        conv_start = 1'b1;
        nstart = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (start) nstart++;
        end
        chk(nstart == 0 && hold == 1, "R8 edge during conversion ignored", nstart, 0);
        conv_start = 1'b0;
        finish_conv("R9 directed");
        nstart = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (start || busy) nstart++;
        end
        chk(nstart == 0, "R8 no queued request after done", nstart, 0);

        // R3: zero-length pulse with edge at same cycle as channel change
        settle_len = '0;
        chan_sel   = chan_sel + 1'b1;
        conv_start = 1'b1;
        @(negedge clk);
        chk(start == 1, "R3 zero length gives no deferral", int'(start), 1);
        conv_start = 1'b0;
        finish_conv("R9 final");

        summary();
    end

endmodule